// File: doc/BRIEF.md
# Three-Phase Gate Control Sequencer

This block is the synchronous decision logic in front of a three-phase half-bridge gate driver. Each phase takes a high-side command (active low) and a low-side command (active high), and drives one gate-enable per switch. Per phase it settles conflicting requests, holds back every turn-on by a programmable number of clock cycles so the two switches of a leg never conduct together, and lets turn-offs through at once. A bypass input turns off both the interlock and the delay, so each gate simply follows its own command.

Two global inputs, a disable and an undervoltage flag, force all six gates off. When both are inactive again, every low-side gate is switched on for a programmable number of cycles to recharge the bootstrap capacitors, and only then does normal command tracking resume. Reset behaves like a release from disable. All command and control inputs pass through a two-flop synchronizer. The dead time and refresh length are static counts in clock cycles.

Top module: `tri_gate_ctrl`

## Requirements
- R1: A high-side command of 0 requests the high gate on and 1 requests it off; a low-side command of 1 requests the low gate on. Any input change reaches the gates on the third rising clock edge after it, unless a delay below applies.
- R2: With dead time active (bypass low, dead count not zero), a phase whose low-side command is 1 drives its low gate on and its high gate off, whatever its high-side command.
- R3: With dead time active, both commands inactive give both gates off, and a high-side request alone gives only the high gate on.
- R4: With the bypass input high, each gate follows its own command with the R1 latency and no interlock, so both gates of one phase may be on together.
- R5: With dead time active, a gate turns off with the R1 latency, and a gate turns on exactly dead_cycles clock edges later than the R1 latency.
- R6: A dead count of zero behaves exactly like the bypass input being high.
- R7: Disable high forces all six gates off with the R1 latency, over every other input.
- R8: Undervoltage high forces all six gates off with the R1 latency, the same as disable.
- R9: When disable and undervoltage are both low again, all three low gates turn on (high gates off) on the fourth rising edge after the release and stay on for refresh_cycles cycles; normal tracking then resumes, with dead time applied to any high-side turn-on. A refresh count of zero skips the pulse.
- R10: During reset all gates are off; after reset the R9 refresh pulse runs first.
- R11: A command change during a pending turn-on delay restarts the delay from the new request; a gate whose request is withdrawn before its delay ends never turns on.
- R12: With dead time active, the two gates of one phase are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd_n | input | PHASES | High-side commands, active low, bit 0 = phase A |
| lo_cmd | input | PHASES | Low-side commands, active high |
| dis_in | input | 1 | Global disable, active high |
| uv_in | input | 1 | Undervoltage flag, active high |
| dt_bypass | input | 1 | Dead-time bypass, active high |
| dead_cycles | input | DT_W | Turn-on delay in clock cycles |
| refresh_cycles | input | RF_W | Refresh pulse length in clock cycles |
| hi_gate | output | PHASES | High-side gate enables |
| lo_gate | output | PHASES | Low-side gate enables |

## Verification
The assertions assume dead_cycles and refresh_cycles stay constant while any phase has a turn-on pending or the refresh pulse is running, and that the bypass input only moves while the commands are quiet. The stimulus therefore changes these settings only with all commands idle or the outputs forced off, and then waits several cycles before giving new commands. Command changes are applied one at a time between clock edges, so each measured latency belongs to a single change.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD    = 2'd0,
        SEQ_REFRESH = 2'd1,
        SEQ_RUN     = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    localparam gate_pair_t PAIR_OFF = '{hi: 1'b0, lo: 1'b0};
    localparam gate_pair_t PAIR_LO  = '{hi: 1'b0, lo: 1'b1};

endpackage

// File: rtl/gdc_sync.sv
module gdc_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/gdc_refresh_seq.sv
module gdc_refresh_seq
    import gdc_pkg::*;
#(
    parameter int RF_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault,
    input  logic [RF_W-1:0] refresh_cycles,
    output logic            gate_off,
    output logic            refresh_on
);

    typedef struct packed {
        seq_state_e      st;
        logic [RF_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SEQ_HOLD: begin
                if (!fault) begin
                    if (refresh_cycles == '0) begin
                        s_d.st = SEQ_RUN;
                    end else begin
                        s_d.st  = SEQ_REFRESH;
                        s_d.cnt = refresh_cycles;
                    end
                end
            end
            SEQ_REFRESH: begin
                if (fault) begin
                    s_d.st = SEQ_HOLD;
                end else if (s_q.cnt <= RF_W'(1)) begin
                    s_d.st  = SEQ_RUN;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SEQ_RUN: begin
                if (fault) begin
                    s_d.st = SEQ_HOLD;
                end
            end
            default: s_d.st = SEQ_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= SEQ_HOLD;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_off   = fault || (s_q.st == SEQ_HOLD);
    assign refresh_on = !fault && (s_q.st == SEQ_REFRESH);

    // R7 R8
    fault_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (s_q.st == SEQ_HOLD));

    // R9
    release_leaves_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_HOLD && !fault) |=> (s_q.st != SEQ_HOLD));

    // R9
    run_needs_refresh_or_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != SEQ_RUN && !fault && !(s_q.st == SEQ_HOLD && refresh_cycles == '0)
         && !(s_q.st == SEQ_REFRESH && s_q.cnt <= RF_W'(1)))
        |=> (s_q.st != SEQ_RUN));

endmodule

// File: rtl/gdc_phase.sv
module gdc_phase
    import gdc_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hi_cmd_n,
    input  logic            lo_cmd,
    input  logic            byp,
    input  logic [DT_W-1:0] dead_cycles,
    input  logic            force_off,
    input  logic            force_lo,
    output logic            hi_gate,
    output logic            lo_gate
);

    typedef struct packed {
        gate_pair_t      req;
        gate_pair_t      out;
        logic [DT_W-1:0] cnt;
    } ph_t;

    ph_t        p_d, p_q;
    gate_pair_t raw, res;

    always_comb begin
        raw.hi = !hi_cmd_n;
        raw.lo = lo_cmd;
        if (lo_cmd) begin
            res = PAIR_LO;
        end else begin
            res.hi = !hi_cmd_n;
            res.lo = 1'b0;
        end
    end

    always_comb begin
        p_d = p_q;
        if (force_off) begin
            p_d.req = PAIR_OFF;
            p_d.out = PAIR_OFF;
            p_d.cnt = '0;
        end else if (force_lo) begin
            p_d.req = PAIR_LO;
            p_d.out = PAIR_LO;
            p_d.cnt = '0;
        end else if (byp) begin
            p_d.req = raw;
            p_d.out = raw;
            p_d.cnt = '0;
        end else if (res != p_q.req) begin
            p_d.req    = res;
            p_d.cnt    = dead_cycles - 1'b1;
            p_d.out.hi = p_q.out.hi & res.hi;
            p_d.out.lo = p_q.out.lo & res.lo;
        end else if (p_q.cnt != '0) begin
            p_d.cnt    = p_q.cnt - 1'b1;
            p_d.out.hi = p_q.out.hi & res.hi;
            p_d.out.lo = p_q.out.lo & res.lo;
        end else begin
            p_d.out = res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign hi_gate = p_q.out.hi;
    assign lo_gate = p_q.out.lo;

    // R12
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byp |=> !(hi_gate && lo_gate));

    // R5 R11
    delay_blocks_turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && !force_off && !force_lo && p_q.cnt != '0) |=> (!$rose(hi_gate) && !$rose(lo_gate)));

    // R7 R8
    forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!hi_gate && !lo_gate));

    // R9
    refresh_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_lo && !force_off) |=> (lo_gate && !hi_gate));

endmodule

// File: rtl/tri_gate_ctrl.sv
module tri_gate_ctrl
    import gdc_pkg::*;
#(
    parameter int PHASES      = 3,
    parameter int DT_W        = 8,
    parameter int RF_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] hi_cmd_n,
    input  logic [PHASES-1:0] lo_cmd,
    input  logic              dis_in,
    input  logic              uv_in,
    input  logic              dt_bypass,
    input  logic [DT_W-1:0]   dead_cycles,
    input  logic [RF_W-1:0]   refresh_cycles,
    output logic [PHASES-1:0] hi_gate,
    output logic [PHASES-1:0] lo_gate
);

    localparam int SW = 2 * PHASES + 3;
    // order: {bypass, uv, dis, lo_cmd, hi_cmd_n}
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, {PHASES{1'b0}}, {PHASES{1'b1}}};

    logic [SW-1:0]     sync_in, sync_out;
    logic [PHASES-1:0] hi_n_s, lo_s;
    logic              dis_s, uv_s, byp_s, byp_eff;
    logic              gate_off, refresh_on;

    assign sync_in = {dt_bypass, uv_in, dis_in, lo_cmd, hi_cmd_n};

    gdc_sync #(
        .W      (SW),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sync_in),
        .dout (sync_out)
    );

    assign hi_n_s  = sync_out[PHASES-1:0];
    assign lo_s    = sync_out[2*PHASES-1:PHASES];
    assign dis_s   = sync_out[2*PHASES];
    assign uv_s    = sync_out[2*PHASES+1];
    assign byp_s   = sync_out[2*PHASES+2];
    assign byp_eff = byp_s || (dead_cycles == '0);

    gdc_refresh_seq #(
        .RF_W(RF_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .fault         (dis_s || uv_s),
        .refresh_cycles(refresh_cycles),
        .gate_off      (gate_off),
        .refresh_on    (refresh_on)
    );

    for (genvar g = 0; g < PHASES; g++) begin : g_phase
        gdc_phase #(
            .DT_W(DT_W)
        ) u_phase (
            .clk        (clk),
            .rst_n      (rst_n),
            .hi_cmd_n   (hi_n_s[g]),
            .lo_cmd     (lo_s[g]),
            .byp        (byp_eff),
            .dead_cycles(dead_cycles),
            .force_off  (gate_off),
            .force_lo   (refresh_on),
            .hi_gate    (hi_gate[g]),
            .lo_gate    (lo_gate[g])
        );
    end

    // R10
    refresh_excludes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_on || gate_off) |=> (hi_gate == '0));

endmodule

// File: tb/tb_tri_gate_ctrl.sv
module tb_tri_gate_ctrl;

    localparam int PH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PH-1:0] hi_cmd_n = '1;
    logic [PH-1:0] lo_cmd = '0;
    logic          dis_in = 1'b0;
    logic          uv_in = 1'b0;
    logic          dt_bypass = 1'b0;
    logic [7:0]    dead_cycles = 8'd4;
    logic [7:0]    refresh_cycles = 8'd5;
    logic [PH-1:0] hi_gate, lo_gate;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    tri_gate_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .hi_cmd_n      (hi_cmd_n),
        .lo_cmd        (lo_cmd),
        .dis_in        (dis_in),
        .uv_in         (uv_in),
        .dt_bypass     (dt_bypass),
        .dead_cycles   (dead_cycles),
        .refresh_cycles(refresh_cycles),
        .hi_gate       (hi_gate),
        .lo_gate       (lo_gate)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // returns the number of rising edges until {hi,lo} == want, or -1
    task automatic wait_for(input logic [5:0] want, output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while ({hi_gate, lo_gate} !== want && n < 300);
        if ({hi_gate, lo_gate} !== want) n = -1;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int n;
        idle(3);
        chk("R10 outputs off in reset", int'({hi_gate, lo_gate}), 0);
        rst_n = 1'b1;
        wait_for(6'b000_111, n);
        chk("R10 refresh starts after reset", n, 4);
        wait_for(6'b000_000, n);
        chk("R9 refresh length", n, 5);
    endtask

    task automatic t_basic();
        int n;
        hi_cmd_n[0] = 1'b0;
        wait_for(6'b001_000, n);
        chk("R5 high turn-on delayed by dead time", n, 7);
        chk("R3 high alone", int'(lo_gate), 0);
        hi_cmd_n[0] = 1'b1;
        wait_for(6'b000_000, n);
        chk("R5 high turn-off immediate", n, 3);
        lo_cmd[1] = 1'b1;
        wait_for(6'b000_010, n);
        chk("R1 low command polarity", n, 7);
        lo_cmd[1] = 1'b0;
        wait_for(6'b000_000, n);
        chk("R3 both inactive off", n, 3);
    endtask

    task automatic t_override();
        int n;
        hi_cmd_n[1] = 1'b0;
        lo_cmd[1]   = 1'b1;
        wait_for(6'b000_010, n);
        chk("R2 low overrides high", n, 7);
        idle(10);
        chk("R2 high stays off", int'({hi_gate, lo_gate}), 2);
        hi_cmd_n[1] = 1'b1;
        lo_cmd[1]   = 1'b0;
        wait_for(6'b000_000, n);
    endtask

    task automatic t_handover();
        int n;
        int overlap = 0;
        hi_cmd_n[2] = 1'b0;
        wait_for(6'b100_000, n);
        hi_cmd_n[2] = 1'b1;
        lo_cmd[2]   = 1'b1;
        wait_for(6'b000_000, n);
        chk("R5 handover turn-off", n, 3);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (hi_gate[2] && lo_gate[2]) overlap++;
        end while (lo_gate[2] !== 1'b1 && n < 50);
        chk("R5 handover turn-on after dead time", n, 4);
        chk("R12 no overlap in handover", overlap, 0);
        lo_cmd[2] = 1'b0;
        wait_for(6'b000_000, n);
    endtask

    task automatic t_bypass();
        int n;
        dt_bypass = 1'b1;
        idle(4);
        hi_cmd_n[0] = 1'b0;
        lo_cmd[0]   = 1'b1;
        wait_for(6'b001_001, n);
        chk("R4 bypass both on", n, 3);
        hi_cmd_n[0] = 1'b1;
        wait_for(6'b000_001, n);
        chk("R4 bypass high off", n, 3);
        lo_cmd[0] = 1'b0;
        wait_for(6'b000_000, n);
        dt_bypass = 1'b0;
        idle(4);
    endtask

    task automatic t_zero_dead();
        int n;
        dead_cycles = 8'd0;
        idle(2);
        hi_cmd_n[1] = 1'b0;
        lo_cmd[1]   = 1'b1;
        wait_for(6'b010_010, n);
        chk("R6 zero dead acts as bypass", n, 3);
        hi_cmd_n[1] = 1'b1;
        lo_cmd[1]   = 1'b0;
        wait_for(6'b000_000, n);
        dead_cycles = 8'd4;
        idle(2);
    endtask

    task automatic t_fault(input bit use_uv);
        int n;
        hi_cmd_n[0] = 1'b0;
        wait_for(6'b001_000, n);
        if (use_uv) uv_in = 1'b1; else dis_in = 1'b1;
        wait_for(6'b000_000, n);
        chk(use_uv ? "R8 undervoltage forces off" : "R7 disable forces off", n, 3);
        lo_cmd[2] = 1'b1;
        dt_bypass = 1'b1;
        idle(10);
        chk(use_uv ? "R8 held off" : "R7 priority over other inputs", int'({hi_gate, lo_gate}), 0);
        lo_cmd[2] = 1'b0;
        dt_bypass = 1'b0;
        idle(4);
        if (use_uv) uv_in = 1'b0; else dis_in = 1'b0;
        wait_for(6'b000_111, n);
        chk("R9 refresh after release", n, 4);
        wait_for(6'b000_000, n);
        chk("R9 refresh length after release", n, 5);
        wait_for(6'b001_000, n);
        chk("R9 high waits dead time after refresh", n, 4);
        hi_cmd_n[0] = 1'b1;
        wait_for(6'b000_000, n);
    endtask

    task automatic t_refresh_zero();
        int n;
        int lo_seen = 0;
        refresh_cycles = 8'd0;
        dis_in = 1'b1;
        idle(5);
        hi_cmd_n[0] = 1'b0;
        idle(4);
        dis_in = 1'b0;
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (lo_gate != '0) lo_seen++;
        end while ({hi_gate, lo_gate} !== 6'b001_000 && n < 50);
        chk("R9 zero refresh skips pulse timing", n, 8);
        chk("R9 zero refresh no low pulse", lo_seen, 0);
        hi_cmd_n[0] = 1'b1;
        wait_for(6'b000_000, n);
        refresh_cycles = 8'd5;
    endtask

    task automatic t_withdraw();
        int n;
        int hi_seen = 0;
        dead_cycles = 8'd10;
        idle(2);
        hi_cmd_n[1] = 1'b0;
        idle(6);
        hi_cmd_n[1] = 1'b1;
        for (int i = 0; i < 25; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (hi_gate[1]) hi_seen++;
        end
        chk("R11 withdrawn request never on", hi_seen, 0);
        hi_cmd_n[1] = 1'b0;
        idle(6);
        lo_cmd[1] = 1'b1;
        wait_for(6'b000_010, n);
        chk("R11 delay restarts on new request", n, 13);
        hi_cmd_n[1] = 1'b1;
        lo_cmd[1]   = 1'b0;
        wait_for(6'b000_000, n);
        dead_cycles = 8'd4;
        idle(2);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_override();
        t_handover();
        t_bypass();
        t_zero_dead();
        t_fault(1'b0);
        t_fault(1'b1);
        t_refresh_zero();
        t_withdraw();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule